// File: doc/BRIEF.md
# General-Purpose Timer with Compare, Capture and Single-Pulse Channel

This block is a 32-bit up-counting timer that sits behind a simple word-addressed register bus. A prescaler divides the clock, and the counter advances once every PSC+1 clocks. It returns to zero after reaching the reload value and raises an update event at that moment. The update event sets a status flag and can raise the interrupt. It can also emit a one-cycle DMA request, so a downstream mover can be paced by the timer period.

A single channel is shared by three uses. It can drive `pwm_o` as an edge-aligned PWM whose compare value may be double-buffered until the next period. It can timestamp edges on `cap_i` into the compare register. It can emit one pulse of programmable length after a trigger. Status flags are cleared by writing zero to them.

Register map (word index on `addr_i`): 0 CTRL (bit0 run, bit3 single-pulse mode), 1 IEN (bit0 update irq, bit1 capture irq, bit8 DMA on update), 2 STAT (bit0 update, bit1 capture, bit9 overcapture), 3 CHMODE (bits[1:0] select 00 output / 01 capture, bit3 compare preload, bits[6:4] output mode, 110 = PWM), 4 CHEN (bit0 channel on, bit1 capture edge 0 rising / 1 falling), 5 CNT, 6 PSC, 7 ARR, 8 CCR.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads 0, and `pwm_o`, `irq_o` and `dma_req_o` are low.
- R2: With CTRL bit0 set, CNT advances by one on every (PSC+1)-th clock and goes from ARR to 0. Writing CNT or PSC restarts the prescale count. With CTRL bit0 clear, CNT holds its value.
- R3: Each step from ARR to 0 sets STAT bit0. `irq_o` is high while STAT bit0 and IEN bit0 are both set, or while STAT bit1 and IEN bit1 are both set.
- R4: A write to STAT clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A flag set by hardware in the same cycle stays set.
- R5: With IEN bit8 set, `dma_req_o` is high for the one cycle after each update event, which is the cycle in which CNT reads 0.
- R6: With CHMODE[1:0]=00, CHMODE[6:4]=110 and CHEN bit0 set, `pwm_o` is high exactly while CNT is below the compare value. With CHEN bit0 clear, `pwm_o` is low.
- R7: With CHMODE bit3 set, a CCR write takes effect as the compare value only from the next update event. With bit3 clear, it takes effect in the cycle after the write.
- R8: With CHMODE[1:0]=01 and CHEN bit0 set, an edge on `cap_i` of the kind chosen by CHEN bit1 (0 rising, 1 falling) copies CNT into CCR and sets STAT bit1. The copy happens on the third clock after the input changes. An edge of the other kind is ignored.
- R9: A capture that happens while STAT bit1 is already set also sets STAT bit9. A capture with STAT bit1 clear leaves bit9 unchanged.
- R10: With CTRL bits 0 and 3 set, the counter idles and `pwm_o` is low. A high `trig_i` restarts CNT from 0, and `pwm_o` (CHMODE[1:0]=00, CHEN bit0) is then high for CCR ticks. At the update event the counter stops at 0 and the output stays low. A trigger during a pulse is ignored.
- R11: If CNT is above ARR, the counter keeps counting up to its full-width maximum and wraps to 0 without an update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| cap_i | input | 1 | Asynchronous capture input |
| trig_i | input | 1 | Single-pulse trigger |
| pwm_o | output | 1 | Channel output |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | One-cycle DMA request on update |

## Verification
A register write lands on the clock edge it is presented at, and read data is due one cycle after the strobe. The counter steps on the same edge as the prescaler expiry, so the bench counts run edges from the enabling write and predicts CNT as floor(edges/(PSC+1)) modulo ARR+1. `pwm_o` follows CNT combinationally, and `dma_req_o` appears one cycle after the wrap edge. The bench therefore samples both at the falling edge after each rising edge and compares them against the edge index. Captures settle three clocks after `cap_i` moves, so the bench holds the input for four cycles and stops the counter before it reads CCR, which makes the stored timestamp exactly the value written to CNT.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_IEN    = 1;
  localparam int REG_STAT   = 2;
  localparam int REG_CHMODE = 3;
  localparam int REG_CHEN   = 4;
  localparam int REG_CNT    = 5;
  localparam int REG_PSC    = 6;
  localparam int REG_ARR    = 7;
  localparam int REG_CCR    = 8;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_OPM_BIT  = 3;
  localparam int IEN_UPD_BIT   = 0;
  localparam int IEN_CAP_BIT   = 1;
  localparam int IEN_DMA_BIT   = 8;
  localparam int STAT_UPD_BIT  = 0;
  localparam int STAT_CAP_BIT  = 1;
  localparam int STAT_OVR_BIT  = 9;
  localparam int MODE_PRE_BIT  = 3;
  localparam int CHEN_ON_BIT   = 0;
  localparam int CHEN_POL_BIT  = 1;

  localparam logic [1:0] SEL_OUT  = 2'b00;
  localparam logic [1:0] SEL_CAP  = 2'b01;
  localparam logic [2:0] OC_PWM1  = 3'b110;
endpackage

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_i,
  input  logic             opm_i,
  input  logic             trig_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             psc_wr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uev_o,
  output logic             armed_o
);
  logic [PSC_W-1:0] psc_cnt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             run, tick, start;

  assign start = cen_i & opm_i & trig_i & ~armed_q;
  assign run   = cen_i & (~opm_i | armed_q);
  assign tick  = run & (psc_cnt_q >= psc_i);
  assign uev_o = tick & (cnt_q == arr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt_q <= '0;
      cnt_q     <= '0;
      armed_q   <= 1'b0;
    end else begin
      if (cnt_wr_i || psc_wr_i || start) psc_cnt_q <= '0;
      else if (run) psc_cnt_q <= tick ? '0 : psc_cnt_q + PSC_W'(1);

      if (cnt_wr_i)   cnt_q <= cnt_wdata_i;
      else if (start) cnt_q <= '0;
      else if (uev_o) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + CNT_W'(1);

      if (!cen_i || !opm_i) armed_q <= 1'b0;
      else if (start)       armed_q <= 1'b1;
      else if (uev_o)       armed_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uev_o && !cnt_wr_i) |=> (cnt_q == '0)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_i && !cnt_wr_i) |=> $stable(cnt_q)); // R2
  AST_OPM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opm_i && cen_i && uev_o && !start) |=> !armed_q); // R10
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             uev_i,
  input  logic [CNT_W-1:0] ccr_i,
  input  logic [1:0]       sel_i,
  input  logic [2:0]       oc_mode_i,
  input  logic             preload_i,
  input  logic             ch_en_i,
  input  logic             pol_i,
  input  logic             opm_i,
  input  logic             armed_i,
  output logic             pwm_o,
  output logic             cap_evt_o
);
  logic             sync_q [SYNC_STAGES];
  logic             prev_q;
  logic             level, edge_hit, below;
  logic [CNT_W-1:0] ccr_act_q, cmp_val;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= cap_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level;
  end

  assign edge_hit  = pol_i ? (prev_q & ~level) : (~prev_q & level);
  assign cap_evt_o = ch_en_i & (sel_i == SEL_CAP) & edge_hit;

  // shadow-to-active transfer only at period boundary when preloading
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ccr_act_q <= '0;
    else if (!preload_i || uev_i) ccr_act_q <= ccr_i;
  end

  assign cmp_val = preload_i ? ccr_act_q : ccr_i;
  assign below   = cnt_i < cmp_val;

  always_comb begin
    pwm_o = 1'b0;
    if (ch_en_i && sel_i == SEL_OUT) begin
      if (opm_i) pwm_o = armed_i & below;
      else       pwm_o = (oc_mode_i == OC_PWM1) & below;
    end
  end

  AST_PWM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_en_i |-> !pwm_o); // R6
  AST_PRELOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload_i && !uev_i) |=> $stable(ccr_act_q)); // R7
  AST_OPM_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opm_i && !armed_i) |-> !pwm_o); // R10
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              uev_i,
  input  logic              cap_evt_i,
  output logic              cen_o,
  output logic              opm_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [CNT_W-1:0]  arr_o,
  output logic [CNT_W-1:0]  ccr_o,
  output logic [1:0]        sel_o,
  output logic [2:0]        oc_mode_o,
  output logic              preload_o,
  output logic              ch_en_o,
  output logic              pol_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              psc_wr_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic cen_q, opm_q, uie_q, ccie_q, ude_q;
  logic uif_q, ccif_q, ovr_q;
  logic [1:0] sel_q;
  logic [2:0] oc_mode_q;
  logic pre_q, ch_en_q, pol_q, dma_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] arr_q, ccr_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic wr, rd;
  logic wr_ctrl, wr_ien, wr_stat, wr_mode, wr_chen, wr_psc, wr_arr, wr_ccr;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_ctrl = wr & (addr_i == ADDR_W'(REG_CTRL));
  assign wr_ien  = wr & (addr_i == ADDR_W'(REG_IEN));
  assign wr_stat = wr & (addr_i == ADDR_W'(REG_STAT));
  assign wr_mode = wr & (addr_i == ADDR_W'(REG_CHMODE));
  assign wr_chen = wr & (addr_i == ADDR_W'(REG_CHEN));
  assign wr_psc  = wr & (addr_i == ADDR_W'(REG_PSC));
  assign wr_arr  = wr & (addr_i == ADDR_W'(REG_ARR));
  assign wr_ccr  = wr & (addr_i == ADDR_W'(REG_CCR));

  assign cnt_wr_o    = wr & (addr_i == ADDR_W'(REG_CNT));
  assign cnt_wdata_o = wdata_i[CNT_W-1:0];
  assign psc_wr_o    = wr_psc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q <= 1'b0; opm_q <= 1'b0;
      uie_q <= 1'b0; ccie_q <= 1'b0; ude_q <= 1'b0;
      sel_q <= '0; oc_mode_q <= '0; pre_q <= 1'b0;
      ch_en_q <= 1'b0; pol_q <= 1'b0;
      psc_q <= '0; arr_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cen_q <= wdata_i[CTRL_RUN_BIT];
        opm_q <= wdata_i[CTRL_OPM_BIT];
      end
      if (wr_ien) begin
        uie_q  <= wdata_i[IEN_UPD_BIT];
        ccie_q <= wdata_i[IEN_CAP_BIT];
        ude_q  <= wdata_i[IEN_DMA_BIT];
      end
      if (wr_mode) begin
        sel_q     <= wdata_i[1:0];
        pre_q     <= wdata_i[MODE_PRE_BIT];
        oc_mode_q <= wdata_i[6:4];
      end
      if (wr_chen) begin
        ch_en_q <= wdata_i[CHEN_ON_BIT];
        pol_q   <= wdata_i[CHEN_POL_BIT];
      end
      if (wr_psc) psc_q <= wdata_i[PSC_W-1:0];
      if (wr_arr) arr_q <= wdata_i[CNT_W-1:0];
    end
  end

  // flags: write-0-to-clear, hardware set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uif_q <= 1'b0; ccif_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      uif_q  <= (uif_q  & ~(wr_stat & ~wdata_i[STAT_UPD_BIT])) | uev_i;
      ccif_q <= (ccif_q & ~(wr_stat & ~wdata_i[STAT_CAP_BIT])) | cap_evt_i;
      ovr_q  <= (ovr_q  & ~(wr_stat & ~wdata_i[STAT_OVR_BIT])) | (cap_evt_i & ccif_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ccr_q <= '0;
    else if (cap_evt_i) ccr_q <= cnt_i;
    else if (wr_ccr)    ccr_q <= wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dma_q <= 1'b0;
    else         dma_q <= uev_i & ude_q;
  end

  always_comb begin
    rdata_d = '0;
    case (addr_i)
      ADDR_W'(REG_CTRL): begin
        rdata_d[CTRL_RUN_BIT] = cen_q;
        rdata_d[CTRL_OPM_BIT] = opm_q;
      end
      ADDR_W'(REG_IEN): begin
        rdata_d[IEN_UPD_BIT] = uie_q;
        rdata_d[IEN_CAP_BIT] = ccie_q;
        rdata_d[IEN_DMA_BIT] = ude_q;
      end
      ADDR_W'(REG_STAT): begin
        rdata_d[STAT_UPD_BIT] = uif_q;
        rdata_d[STAT_CAP_BIT] = ccif_q;
        rdata_d[STAT_OVR_BIT] = ovr_q;
      end
      ADDR_W'(REG_CHMODE): begin
        rdata_d[1:0]          = sel_q;
        rdata_d[MODE_PRE_BIT] = pre_q;
        rdata_d[6:4]          = oc_mode_q;
      end
      ADDR_W'(REG_CHEN): begin
        rdata_d[CHEN_ON_BIT]  = ch_en_q;
        rdata_d[CHEN_POL_BIT] = pol_q;
      end
      ADDR_W'(REG_CNT): rdata_d = DATA_W'(cnt_i);
      ADDR_W'(REG_PSC): rdata_d = DATA_W'(psc_q);
      ADDR_W'(REG_ARR): rdata_d = DATA_W'(arr_q);
      ADDR_W'(REG_CCR): rdata_d = DATA_W'(ccr_q);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rdata_d;
  end

  assign rdata_o   = rdata_q;
  assign irq_o     = (uif_q & uie_q) | (ccif_q & ccie_q);
  assign dma_req_o = dma_q;
  assign cen_o     = cen_q;
  assign opm_o     = opm_q;
  assign psc_o     = psc_q;
  assign arr_o     = arr_q;
  assign ccr_o     = ccr_q;
  assign sel_o     = sel_q;
  assign oc_mode_o = oc_mode_q;
  assign preload_o = pre_q;
  assign ch_en_o   = ch_en_q;
  assign pol_o     = pol_q;

  AST_UIF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uev_i |=> uif_q); // R3
  AST_CCIF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> ccif_q); // R8
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && ccif_q) |=> ovr_q); // R9
  AST_DMA_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> $past(uev_i && ude_q)); // R5
endmodule

// File: rtl/gp_timer.sv
module gp_timer #(
  parameter int CNT_W       = 32,
  parameter int PSC_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cap_i,
  input  logic              trig_i,
  output logic              pwm_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic             cen, opm, preload, ch_en, pol, cnt_wr, psc_wr, uev, armed, cap_evt;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] arr, ccr, cnt, cnt_wdata;
  logic [1:0]       sel;
  logic [2:0]       oc_mode;

  gpt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_i(cnt), .uev_i(uev), .cap_evt_i(cap_evt),
    .cen_o(cen), .opm_o(opm), .psc_o(psc), .arr_o(arr), .ccr_o(ccr), .sel_o(sel),
    .oc_mode_o(oc_mode), .preload_o(preload), .ch_en_o(ch_en), .pol_o(pol),
    .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata), .psc_wr_o(psc_wr),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  gpt_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .cen_i(cen), .opm_i(opm), .trig_i(trig_i),
    .psc_i(psc), .arr_i(arr), .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
    .psc_wr_i(psc_wr), .cnt_o(cnt), .uev_o(uev), .armed_o(armed)
  );

  gpt_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_channel (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_i), .cnt_i(cnt), .uev_i(uev),
    .ccr_i(ccr), .sel_i(sel), .oc_mode_i(oc_mode), .preload_i(preload),
    .ch_en_i(ch_en), .pol_i(pol), .opm_i(opm), .armed_i(armed),
    .pwm_o(pwm_o), .cap_evt_o(cap_evt)
  );
endmodule

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
  localparam logic [3:0] A_CTRL = 4'd0, A_IEN = 4'd1, A_STAT = 4'd2, A_MODE = 4'd3,
                         A_CHEN = 4'd4, A_CNT = 4'd5, A_PSC = 4'd6, A_ARR = 4'd7,
                         A_CCR = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cap = 1'b0, trig = 1'b0;
  logic        pwm, irq, dma;
  int          checks = 0, errors = 0, cyc = 0;

  gp_timer u_gp_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .trig_i(trig),
    .pwm_o(pwm), .irq_o(irq), .dma_req_o(dma)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<=50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; consumes one rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata; req = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 pwm reset", {31'h0, pwm}, 32'h0);
    chk("R1 irq reset", {31'h0, irq}, 32'h0);
    chk("R1 dma reset", {31'h0, dma}, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(A_CTRL, 0); wr(A_PSC, 2); wr(A_ARR, 4); wr(A_CNT, 0); wr(A_STAT, 0);
    wr(A_CTRL, 1);
    repeat (19) @(negedge clk);
    wr(A_CTRL, 0);                       // 20 run edges -> 6 ticks
    rd(A_CNT, v);  chk("R2 count after 20 edges", v, 32'd1);
    repeat (5) @(negedge clk);
    rd(A_CNT, v);  chk("R2 hold while stopped", v, 32'd1);
    rd(A_STAT, v); chk("R3 update flag", v, 32'h1);
    chk("R3 irq masked", {31'h0, irq}, 32'h0);
    wr(A_IEN, 1);
    chk("R3 irq enabled", {31'h0, irq}, 32'h1);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R4 write one keeps", v, 32'h1);
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R4 write zero clears", v, 32'h0);
    chk("R4 irq drops", {31'h0, irq}, 32'h0);
    wr(A_IEN, 0);
  endtask

  task automatic t_stat_race;
    logic [31:0] v;
    wr(A_PSC, 0); wr(A_ARR, 0); wr(A_CNT, 0); wr(A_CTRL, 1);
    wr(A_STAT, 0);                       // update on this very edge
    wr(A_CTRL, 0);
    rd(A_STAT, v); chk("R4 set beats clear", v, 32'h1);
    wr(A_STAT, 0);
  endtask

  task automatic t_dma;
    wr(A_IEN, 32'h100); wr(A_PSC, 0); wr(A_ARR, 3); wr(A_CNT, 0); wr(A_STAT, 0);
    wr(A_CTRL, 1);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      chk($sformatf("R5 dma edge %0d", i), {31'h0, dma}, {31'h0, (i % 4) == 0});
    end
    chk("R3 irq stays low without enable", {31'h0, irq}, 32'h0);
    wr(A_CTRL, 0); wr(A_IEN, 0); wr(A_STAT, 0);
  endtask

  task automatic t_pwm;
    wr(A_PSC, 0); wr(A_ARR, 9); wr(A_CCR, 4); wr(A_MODE, 32'h60); wr(A_CHEN, 1);
    wr(A_CNT, 0); wr(A_CTRL, 1);
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      chk($sformatf("R6 pwm edge %0d", i), {31'h0, pwm}, {31'h0, (i % 10) < 4});
    end
    wr(A_CHEN, 0);
    chk("R6 pwm off when disabled", {31'h0, pwm}, 32'h0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_preload;
    logic e;
    wr(A_CHEN, 1); wr(A_MODE, 32'h60); wr(A_CCR, 4); wr(A_MODE, 32'h68);
    wr(A_PSC, 0); wr(A_ARR, 9); wr(A_CNT, 0);
    wr(A_CTRL, 1);
    repeat (2) @(negedge clk);
    wr(A_CCR, 7);                        // mid-period, held in shadow
    for (int i = 4; i <= 19; i++) begin
      @(negedge clk);
      e = (i < 10) ? (i < 4) : ((i - 10) < 7);
      chk($sformatf("R7 preload edge %0d", i), {31'h0, pwm}, {31'h0, e});
    end
    wr(A_MODE, 32'h60);
    wr(A_CCR, 2);
    @(negedge clk);                      // CNT = 2
    chk("R7 no preload immediate", {31'h0, pwm}, 32'h0);
    wr(A_CTRL, 0); wr(A_CHEN, 0); wr(A_MODE, 0);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    wr(A_STAT, 0); wr(A_IEN, 2); wr(A_MODE, 1); wr(A_CHEN, 1); wr(A_CNT, 32'h1234);
    cap = 1'b1; repeat (4) @(negedge clk);
    rd(A_CCR, v);  chk("R8 rising capture value", v, 32'h1234);
    rd(A_STAT, v); chk("R8 capture flag", v, 32'h2);
    chk("R8 capture irq", {31'h0, irq}, 32'h1);
    wr(A_CNT, 32'h99);
    cap = 1'b0; repeat (4) @(negedge clk);
    rd(A_CCR, v);  chk("R8 falling ignored on rising", v, 32'h1234);
    rd(A_STAT, v); chk("R9 no overcapture", v, 32'h2);
    wr(A_STAT, 0); wr(A_CHEN, 3); wr(A_CNT, 32'h77);
    cap = 1'b1; repeat (4) @(negedge clk);
    rd(A_CCR, v);  chk("R8 rising ignored on falling", v, 32'h1234);
    cap = 1'b0; repeat (4) @(negedge clk);
    rd(A_CCR, v);  chk("R8 falling capture value", v, 32'h77);
    wr(A_CNT, 32'h88);
    cap = 1'b1; repeat (4) @(negedge clk);
    cap = 1'b0; repeat (4) @(negedge clk);
    rd(A_CCR, v);  chk("R9 second capture value", v, 32'h88);
    rd(A_STAT, v); chk("R9 overcapture flag", v, 32'h202);
    wr(A_STAT, 0); wr(A_IEN, 0); wr(A_CHEN, 0); wr(A_MODE, 0);
  endtask

  task automatic t_opm;
    logic [31:0] v;
    wr(A_MODE, 0); wr(A_CHEN, 1); wr(A_PSC, 0); wr(A_ARR, 9); wr(A_CCR, 3);
    wr(A_CNT, 0); wr(A_CTRL, 32'h9);
    repeat (3) @(negedge clk);
    chk("R10 idle low", {31'h0, pwm}, 32'h0);
    rd(A_CNT, v); chk("R10 idle count", v, 32'h0);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk("R10 pulse start", {31'h0, pwm}, 32'h1);
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      chk($sformatf("R10 pulse edge %0d", i), {31'h0, pwm}, {31'h0, i < 3});
      trig = (i == 5);                   // retrigger during pulse
    end
    rd(A_CNT, v); chk("R10 stopped at zero", v, 32'h0);
    wr(A_CTRL, 0); wr(A_CHEN, 0); wr(A_STAT, 0);
  endtask

  task automatic t_arr_below;
    logic [31:0] v;
    wr(A_ARR, 5); wr(A_PSC, 0); wr(A_CNT, 32'hFFFF_FFF0); wr(A_STAT, 0);
    wr(A_CTRL, 1);
    repeat (15) @(negedge clk);
    wr(A_CTRL, 0);                       // 16 ticks
    rd(A_CNT, v);  chk("R11 full-width wrap", v, 32'h0);
    rd(A_STAT, v); chk("R11 no update on overflow", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_stat_race();
    t_dma();
    t_pwm();
    t_preload();
    t_capture();
    t_opm();
    t_arr_below();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule